// File: doc/BRIEF.md
# UART Interrupt Event Collector

This block gathers the interrupt-worthy events of one UART channel into a single 8-bit status word and pairs that word with an 8-bit enable mask. Six of the status bits are sticky. Each one is set by a single-cycle pulse from the UART datapath and cleared by its own bus side-effect, which arrives as a strobe: a receive-buffer read, a transmit-buffer write, a receiver or transmitter enable command, a break-change acknowledge, or an input-change acknowledge. The remaining two bits are live copies of receiver and transmitter readiness.

Status and mask share one bus location. A read always returns the status word on `rd_data_o`, and a write (`wr_en_i`) loads the mask. The mask can never be read back, and status bits cannot be written. A single registered interrupt request is raised whenever any status bit is set under an enabled mask bit. All ports are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_evt_irq`

## Requirements
- R1: After reset, the status word reads 0x00 (with the readiness inputs low), the mask is 0x00 and `irq_o` is 0.
- R2: Status bit positions are fixed: 7 line-change, 6 rate-found, 5 rx-FIFO event, 4 tx-FIFO event, 3 rx timeout, 2 break-change, 1 rx readiness, 0 tx readiness.
- R3: Bit 7 sets on `cts_edge_i` only while `cts_irq_en_i` is 1, and clears on `cts_ack_i`.
- R4: Bit 6 sets on `baud_loaded_i` and clears only on `enable_cmd_i`. Buffer reads and writes leave it set.
- R5: Bit 5 sets on `rx_fifo_evt_i` and bit 3 sets on `rx_tmo_evt_i`. Both clear on `rxbuf_rd_i`.
- R6: Bit 4 sets on `tx_fifo_evt_i` and clears on `txbuf_wr_i`.
- R7: Bit 2 sets on `brk_edge_i`, which marks a break starting or ending, and clears on `brk_ack_i`.
- R8: Bit 1 equals `rx_ready_i` when `full_sel_i` is 0, and equals `rx_full_i` when `full_sel_i` is 1.
- R9: Bit 0 equals `thr_empty_i` while `tx_enable_i` is 1, and is 0 while `tx_enable_i` is 0.
- R10: When a set pulse and the clear strobe of the same sticky bit arrive in the same cycle, the bit ends up set.
- R11: A write loads the mask from `wr_data_i` and leaves the status word unchanged. A read shows only status.
- R12: `irq_o` in cycle n+1 equals the OR of (status AND mask) in cycle n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the shared location (loads the mask) |
| wr_data_i | input | 8 | Mask value to load |
| rd_data_o | output | 8 | Status word |
| cts_edge_i | input | 1 | Pulse: transition seen on the clear-to-send input |
| cts_irq_en_i | input | 1 | Level: transitions on clear-to-send may raise bit 7 |
| cts_ack_i | input | 1 | Strobe: clears bit 7 |
| baud_loaded_i | input | 1 | Pulse: a measured divisor has been loaded |
| enable_cmd_i | input | 1 | Strobe: receiver or transmitter enable command written |
| rx_fifo_evt_i | input | 1 | Pulse: programmed receive-FIFO condition |
| rx_tmo_evt_i | input | 1 | Pulse: receive-FIFO timeout |
| rxbuf_rd_i | input | 1 | Strobe: receive buffer read |
| tx_fifo_evt_i | input | 1 | Pulse: programmed transmit-FIFO condition |
| txbuf_wr_i | input | 1 | Strobe: transmit buffer written |
| brk_edge_i | input | 1 | Pulse: break began or ended |
| brk_ack_i | input | 1 | Strobe: clears bit 2 |
| rx_ready_i | input | 1 | Level: receiver holds a character |
| rx_full_i | input | 1 | Level: receive FIFO full |
| full_sel_i | input | 1 | Level: 1 selects FIFO-full for bit 1 |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| tx_enable_i | input | 1 | Level: transmitter enabled |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters, which give the full eight-bit layout of six sticky bits and two live bits, so every set, clear and mirror path is reachable. Random pulses with a high collision rate drive set and clear strobes of the same bit into the same cycle. The mask is rewritten often, so the interrupt path is tested under many partial masks. Directed steps cover the rate-found bit surviving buffer traffic, a line change ignored while its enable is off, and the transmitter-disabled override.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int unsigned EVT_W    = 8;
  localparam int unsigned LIVE_W   = 2;
  localparam int unsigned STICKY_W = EVT_W - LIVE_W;
  // status bit positions (software decodes these)
  localparam int unsigned B_TXRDY  = 0;
  localparam int unsigned B_RXRDY  = 1;
  localparam int unsigned B_BRK    = 2;
  localparam int unsigned B_RXTMO  = 3;
  localparam int unsigned B_TXFIFO = 4;
  localparam int unsigned B_RXFIFO = 5;
  localparam int unsigned B_BAUD   = 6;
  localparam int unsigned B_LINE   = 7;
endpackage

// File: rtl/evt_sticky.sv
module evt_sticky #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]);
    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/ready_mirror.sv
module ready_mirror (
  input  logic       rx_ready_i,
  input  logic       rx_full_i,
  input  logic       full_sel_i,
  input  logic       thr_empty_i,
  input  logic       tx_enable_i,
  output logic [1:0] live_o
);
  always_comb begin
    live_o[1] = full_sel_i ? rx_full_i : rx_ready_i;
    live_o[0] = thr_empty_i & tx_enable_i;
  end
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] status_i,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i) mask_q <= wr_data_i;
      irq_q <= |(status_i & mask_q);
    end
  end
  assign irq_o = irq_q;

  assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_q == $past(wr_data_i)));
  assert_irq_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i & mask_q) != '0 |=> irq_o);
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i & mask_q) == '0 |=> !irq_o);
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq
  import uart_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       cts_edge_i,
  input  logic       cts_irq_en_i,
  input  logic       cts_ack_i,
  input  logic       baud_loaded_i,
  input  logic       enable_cmd_i,
  input  logic       rx_fifo_evt_i,
  input  logic       rx_tmo_evt_i,
  input  logic       rxbuf_rd_i,
  input  logic       tx_fifo_evt_i,
  input  logic       txbuf_wr_i,
  input  logic       brk_edge_i,
  input  logic       brk_ack_i,
  input  logic       rx_ready_i,
  input  logic       rx_full_i,
  input  logic       full_sel_i,
  input  logic       thr_empty_i,
  input  logic       tx_enable_i,
  output logic       irq_o
);
  logic [STICKY_W-1:0] set_v, clr_v, sticky_q;
  logic [LIVE_W-1:0]   live;
  logic [EVT_W-1:0]    status;

  // sticky vector index k holds status bit k + LIVE_W
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[B_LINE   - LIVE_W] = cts_edge_i & cts_irq_en_i;
    clr_v[B_LINE   - LIVE_W] = cts_ack_i;
    set_v[B_BAUD   - LIVE_W] = baud_loaded_i;
    clr_v[B_BAUD   - LIVE_W] = enable_cmd_i;
    set_v[B_RXFIFO - LIVE_W] = rx_fifo_evt_i;
    clr_v[B_RXFIFO - LIVE_W] = rxbuf_rd_i;
    set_v[B_TXFIFO - LIVE_W] = tx_fifo_evt_i;
    clr_v[B_TXFIFO - LIVE_W] = txbuf_wr_i;
    set_v[B_RXTMO  - LIVE_W] = rx_tmo_evt_i;
    clr_v[B_RXTMO  - LIVE_W] = rxbuf_rd_i;
    set_v[B_BRK    - LIVE_W] = brk_edge_i;
    clr_v[B_BRK    - LIVE_W] = brk_ack_i;
  end

  evt_sticky #(.W(STICKY_W)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .q_o(sticky_q)
  );

  ready_mirror u_mirror (
    .rx_ready_i(rx_ready_i), .rx_full_i(rx_full_i), .full_sel_i(full_sel_i),
    .thr_empty_i(thr_empty_i), .tx_enable_i(tx_enable_i), .live_o(live)
  );

  assign status    = {sticky_q, live};
  assign rd_data_o = status;

  irq_gen #(.W(EVT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .status_i(status), .irq_o(irq_o)
  );

  assert_line_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_irq_en_i && !rd_data_o[B_LINE]) |=> !rd_data_o[B_LINE]);
  assert_baud_survives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[B_BAUD] && !enable_cmd_i) |=> rd_data_o[B_BAUD]);
  assert_tx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable_i |-> !rd_data_o[B_TXRDY]);
  assert_write_no_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && set_v == '0 && clr_v == '0) |=> $stable(sticky_q));
endmodule

// File: tb/uart_evt_irq_bench.sv
module uart_evt_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [7:0] wr_data = 0; logic [7:0] rd_data;
  logic cts_edge = 0, cts_en = 0, cts_ack = 0, baud_ld = 0, en_cmd = 0;
  logic rx_evt = 0, rx_tmo = 0, rx_rd = 0, tx_evt = 0, tx_wr = 0;
  logic brk_edge = 0, brk_ack = 0, rx_rdy = 0, rx_full = 0, fsel = 0;
  logic thr_empty = 0, tx_en = 0;
  logic irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_evt_irq u_uart_evt_irq (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .cts_edge_i(cts_edge), .cts_irq_en_i(cts_en),
    .cts_ack_i(cts_ack), .baud_loaded_i(baud_ld), .enable_cmd_i(en_cmd),
    .rx_fifo_evt_i(rx_evt), .rx_tmo_evt_i(rx_tmo), .rxbuf_rd_i(rx_rd),
    .tx_fifo_evt_i(tx_evt), .txbuf_wr_i(tx_wr), .brk_edge_i(brk_edge),
    .brk_ack_i(brk_ack), .rx_ready_i(rx_rdy), .rx_full_i(rx_full),
    .full_sel_i(fsel), .thr_empty_i(thr_empty), .tx_enable_i(tx_en),
    .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:2] m_st;
  bit [7:0] m_mask;
  bit       m_irq;

  function automatic bit [7:0] model_status();
    bit b1, b0;
    b1 = fsel ? rx_full : rx_rdy;
    b0 = tx_en ? thr_empty : 1'b0;
    return {m_st, b1, b0};
  endfunction

  function automatic bit nxt(bit cur, bit s, bit c);
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= '0; m_mask <= '0; m_irq <= 1'b0;
    end else begin
      m_irq  <= |(model_status() & m_mask);
      if (wr_en) m_mask <= wr_data;
      m_st[7] <= nxt(m_st[7], cts_edge && cts_en, cts_ack);
      m_st[6] <= nxt(m_st[6], baud_ld, en_cmd);
      m_st[5] <= nxt(m_st[5], rx_evt, rx_rd);
      m_st[4] <= nxt(m_st[4], tx_evt, tx_wr);
      m_st[3] <= nxt(m_st[3], rx_tmo, rx_rd);
      m_st[2] <= nxt(m_st[2], brk_edge, brk_ack);
    end
  end

  function automatic string bit_req(int i);
    case (i)
      7: return "R3"; 6: return "R4"; 5: return "R5"; 4: return "R6";
      3: return "R5"; 2: return "R7"; 1: return "R8"; default: return "R9";
    endcase
  endfunction

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [7:0] exp_s;
      exp_s = model_status();
      vectors++;
      if (rd_data !== exp_s) begin
        miscompares++;
        for (int i = 0; i < 8; i++)
          if (rd_data[i] !== exp_s[i])
            $display("FAIL %s (R2 bit %0d): status got %02h expected %02h",
                     bit_req(i), i, rd_data, exp_s);
      end
      vectors++;
      if (irq !== m_irq) begin
        miscompares++;
        $display("FAIL R12: irq got %0b expected %0b", irq, m_irq);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; cts_edge = 0; cts_ack = 0; baud_ld = 0; en_cmd = 0;
    rx_evt = 0; rx_tmo = 0; rx_rd = 0; tx_evt = 0; tx_wr = 0;
    brk_edge = 0; brk_ack = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    check("R1 status", rd_data, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R11: mask write leaves status untouched, read shows status only
    wr_en = 1; wr_data = 8'hFF; tick(); settle();
    check("R11 read after mask write", rd_data, 8'h00);
    check("R11 mask not readable, irq low", {7'd0, irq}, 8'h00);

    // R10: set and clear together -> set
    rx_evt = 1; rx_rd = 1; tick(); settle();
    check("R10 collision keeps bit 5", rd_data, 8'h20);
    tick(); settle();
    check("R12 irq after masked bit", {7'd0, irq}, 8'h01);
    rx_rd = 1; tick(); settle();
    check("R5 rx read clears bit 5", rd_data, 8'h00);

    // R5 timeout bit
    rx_tmo = 1; tick(); settle();
    check("R5 timeout sets bit 3", rd_data, 8'h08);
    rx_rd = 1; tick(); settle();
    check("R5 rx read clears bit 3", rd_data, 8'h00);

    // R4: rate-found survives buffer traffic
    baud_ld = 1; tick(); settle();
    rx_rd = 1; tx_wr = 1; cts_ack = 1; brk_ack = 1; tick(); settle();
    check("R4 bit 6 survives other clears", rd_data, 8'h40);
    en_cmd = 1; tick(); settle();
    check("R4 enable command clears bit 6", rd_data, 8'h00);

    // R3: line change gated by enable
    cts_en = 0; cts_edge = 1; tick(); settle();
    check("R3 disabled change ignored", rd_data, 8'h00);
    cts_en = 1; cts_edge = 1; tick(); settle();
    check("R3 enabled change sets bit 7", rd_data, 8'h80);
    cts_ack = 1; tick(); settle();
    check("R3 ack clears bit 7", rd_data, 8'h00);

    // R6, R7
    tx_evt = 1; brk_edge = 1; tick(); settle();
    check("R6/R7 set bits 4 and 2", rd_data, 8'h14);
    tx_wr = 1; tick(); settle();
    check("R6 tx write clears bit 4", rd_data, 8'h04);
    brk_ack = 1; tick(); settle();
    check("R7 ack clears bit 2", rd_data, 8'h00);

    // R8, R9 live bits
    rx_rdy = 1; rx_full = 0; fsel = 0; #1;
    check("R8 select ready", rd_data, 8'h02);
    fsel = 1; #1;
    check("R8 select full", rd_data, 8'h00);
    thr_empty = 1; tx_en = 0; #1;
    check("R9 disabled forces 0", rd_data, 8'h00);
    tx_en = 1; #1;
    check("R9 enabled mirrors empty", rd_data, 8'h01);

    // R12: clearing mask drops irq one cycle after
    tick(); settle();
    check("R12 irq with bit 0 masked on", {7'd0, irq}, 8'h01);
    wr_en = 1; wr_data = 8'h00; tick(); tick(); settle();
    check("R12 irq low after mask cleared", {7'd0, irq}, 8'h00);

    // random phase, compared against the model every cycle
    for (int n = 0; n < RAND_CYCLES; n++) begin
      wr_en     = ($urandom_range(0, 7) == 0);
      wr_data   = 8'($urandom);
      cts_edge  = ($urandom_range(0, 3) == 0);
      cts_en    = ($urandom_range(0, 1) == 0);
      cts_ack   = ($urandom_range(0, 4) == 0);
      baud_ld   = ($urandom_range(0, 5) == 0);
      en_cmd    = ($urandom_range(0, 5) == 0);
      rx_evt    = ($urandom_range(0, 3) == 0);
      rx_tmo    = ($urandom_range(0, 4) == 0);
      rx_rd     = ($urandom_range(0, 3) == 0);
      tx_evt    = ($urandom_range(0, 3) == 0);
      tx_wr     = ($urandom_range(0, 3) == 0);
      brk_edge  = ($urandom_range(0, 4) == 0);
      brk_ack   = ($urandom_range(0, 4) == 0);
      rx_rdy    = $urandom_range(0, 1);
      rx_full   = $urandom_range(0, 1);
      fsel      = $urandom_range(0, 1);
      thr_empty = $urandom_range(0, 1);
      tx_en     = $urandom_range(0, 1);
      @(posedge clk); #1;
    end
    tick(); settle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule